// File: doc/BRIEF.md
# Programmable Interval Timer Channel

One 16-bit binary down-counter channel of an interval timer. Software programs it over a byte-wide port. A control write picks one of six output behaviours and how the count is transferred: low byte only, high byte only, or low byte followed by high byte. Data writes then supply the initial count. The channel acts only once a complete count has arrived after the control write. It counts one step per `clk` cycle. `gate` enables counting or triggers it, depending on the behaviour, and `out` carries the resulting waveform. An initial count of 0 stands for 65536.

Reads return the count one byte at a time. A latch command freezes a snapshot so that the two byte reads of a free-running count belong together. A status read reports the output level, whether a count is still missing, and the programmed configuration.

Control word layout: bits 5:4 select access (00 latch command, 01 low byte only, 10 high byte only, 11 low then high), bits 3:1 select the mode, bits 7:6 and 0 are ignored. Modes 2 and 3 are the rate generator and the square wave. For counts of 2 or more, a data write while either of them is running takes effect at the next reload.

Top module: `pit_channel`

## Requirements
- R1: A control write with a nonzero access field sets `out` low on the next cycle for mode 0 and high for every other mode; after reset `out` is high.
- R2: When mode bit 2 (middle) is set, mode bit 3 is ignored, so codes 6 and 7 act as modes 2 and 3 and the status byte reports mode 2 or 3.
- R3: Mode 0: the count N loads one cycle after the last count byte is written. `out` stays low and rises N+1 cycles after that write. Every cycle with `gate` low delays the rise by one.
- R4: Mode 1: a rising `gate` loads N and drives `out` low for N cycles regardless of later `gate` level. A new rising edge during the pulse reloads N and extends the pulse.
- R5: Mode 2: with `gate` high, `out` repeats a period of N cycles from the load, high except for the last cycle of each period.
- R6: Mode 3: with `gate` high, `out` repeats a period of N cycles, high for (N+1)/2 cycles then low for N/2 cycles (integer division).
- R7: Mode 4: `out` goes low for exactly one cycle, N+1 cycles after the count write, and then stays high.
- R8: Mode 5: a rising `gate` loads N; `out` goes low for one cycle N cycles later, and each further rising edge repeats this.
- R9: In modes 2 and 3, `gate` low holds the count and forces `out` high on the next cycle; a rising `gate` restarts the period from the load.
- R10: Access field 01 writes only the low byte (high byte zero), 10 writes only the high byte (low byte zero), 11 takes the low byte then the high byte.
- R11: A latch command (access field 00) captures the count it sees; data reads return the low then the high byte of that snapshot until the final byte is read.
- R12: A status read returns {out, count-missing, access[1:0], mode[2:0], 0}; reset gives 0xF0.
- R13: A control write resets the byte order of writes and reads and discards a pending latch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; also the count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate | input | 1 | Count enable or trigger |
| wr_en | input | 1 | Write strobe |
| ctrl_sel | input | 1 | Write target: 1 control word, 0 count byte |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Data read strobe; advances the read byte order |
| rd_stat | input | 1 | Select status byte on rd_data |
| rd_data | output | 8 | Read data (combinational) |
| out | output | 1 | Timer output |

## Verification
The channel has no parameters, so the bench builds the single 16-bit configuration. It therefore keeps counts small (2 to 31, one high-byte-only count of 256) so that complete periods fit the run. The 0 = 65536 case is left out of reach for that reason. Random modes 2, 3, 6 and 7 with random counts sweep odd and even square-wave splits. Directed runs cover gate pauses, one-shot retrigger, latch snapshots and byte-order reset.

// File: rtl/pit_channel.sv
module pit_channel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate,
  input  logic       wr_en,
  input  logic       ctrl_sel,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       rd_stat,
  output logic [7:0] rd_data,
  output logic       out
);
  logic [2:0]  m;
  logic [1:0]  rw;
  logic [15:0] init, cnt, lval;
  logic        armed, run, load_pend, latched, wptr, rptr, gate_q;

  logic unused_bits;
  assign unused_bits = ^{wr_data[7:6], wr_data[0]};

  wire        rise    = gate & ~gate_q;
  wire [2:0]  wm      = wr_data[2] ? {1'b0, wr_data[2:1]} : wr_data[3:1];
  wire [16:0] n_full  = (init == 16'd0) ? 17'h10000 : {1'b0, init};
  wire [15:0] hi_len  = 16'((n_full + 17'd1) >> 1);
  wire [15:0] lo_len  = 16'(n_full >> 1);
  wire        rate    = (m == 3'd2) || (m == 3'd3);
  wire        trig    = (m == 3'd1) || (m == 3'd5);
  wire        en_cnt  = gate | trig;
  wire        cmpl    = (rw != 2'b11) | wptr;
  wire [15:0] rv      = latched ? lval : cnt;
  wire        rd_hi   = (rw == 2'b10) | ((rw == 2'b11) & rptr);
  wire        rd_last = (rw != 2'b11) | rptr;

  assign rd_data = rd_stat ? {out, ~armed, rw, m, 1'b0} : (rd_hi ? rv[15:8] : rv[7:0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m <= 3'd0; rw <= 2'b11; init <= 16'd0; cnt <= 16'd0; lval <= 16'd0;
      armed <= 1'b0; run <= 1'b0; load_pend <= 1'b0; latched <= 1'b0;
      wptr <= 1'b0; rptr <= 1'b0; gate_q <= 1'b0; out <= 1'b1;
    end else begin
      gate_q <= gate;
      if (rd_en && !rd_stat) begin
        if (rw == 2'b11) rptr <= ~rptr;
        if (rd_last) latched <= 1'b0;
      end
      if (wr_en && ctrl_sel) begin
        if (wr_data[5:4] == 2'b00) begin
          if (!latched) begin
            latched <= 1'b1;
            lval    <= cnt;
          end
        end else begin
          rw <= wr_data[5:4]; m <= wm;
          wptr <= 1'b0; rptr <= 1'b0; latched <= 1'b0;
          armed <= 1'b0; run <= 1'b0; load_pend <= 1'b0;
          out <= (wm != 3'd0);
        end
      end else begin
        if (load_pend) begin
          load_pend <= 1'b0;
          run <= 1'b1;
          cnt <= (m == 3'd3) ? hi_len : init;
          if (m != 3'd0) out <= 1'b1;
        end else if (trig && rise && armed) begin
          cnt <= init; run <= 1'b1; out <= (m == 3'd5);
        end else if (rate && rise && armed) begin
          cnt <= (m == 3'd3) ? hi_len : init; run <= 1'b1; out <= 1'b1;
        end else if (rate && !gate) begin
          out <= 1'b1;
        end else if (run && en_cnt) begin
          case (m)
            3'd2: if (cnt == 16'd1) begin
                    cnt <= init; out <= 1'b1;
                  end else begin
                    cnt <= cnt - 16'd1; out <= (cnt != 16'd2);
                  end
            3'd3: if (cnt == 16'd1) begin
                    out <= ~out; cnt <= out ? lo_len : hi_len;
                  end else cnt <= cnt - 16'd1;
            default: begin
              cnt <= cnt - 16'd1;
              if (cnt == 16'd1) begin
                run <= 1'b0;
                out <= (m == 3'd0) || (m == 3'd1);
              end else if (m[2]) out <= 1'b1;
            end
          endcase
        end else if (m[2]) out <= 1'b1;

        if (wr_en) begin
          case (rw)
            2'b01:   init <= {8'h00, wr_data};
            2'b10:   init <= {wr_data, 8'h00};
            default: begin
              if (!wptr) init[7:0] <= wr_data;
              else       init[15:8] <= wr_data;
              wptr <= ~wptr;
            end
          endcase
          if (cmpl) begin
            armed <= 1'b1;
            load_pend <= (m == 3'd0) || (m == 3'd4) || (rate && !run);
            if (m == 3'd0) out <= 1'b0;
            if ((m == 3'd0) || (m == 3'd4)) run <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pit_channel_checks.sv
module pit_channel_checks (
  input logic        clk,
  input logic        rst_n,
  input logic        gate,
  input logic        wr_en,
  input logic        ctrl_sel,
  input logic [5:1]  ctl,
  input logic        out,
  input logic [2:0]  m,
  input logic        latched,
  input logic [15:0] lval
);
  wire cw = wr_en && ctrl_sel && (ctl[5:4] != 2'b00);

  assert_idle_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> (out == ($past(ctl[3:1]) != 3'd0)));

  assert_rate_low_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m == 3'd2 && !out && !(wr_en && ctrl_sel)) |=> out);

  assert_strobe_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m[2] && !out && !(wr_en && ctrl_sel)) |=> out);

  assert_gate_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((m == 3'd2 || m == 3'd3) && !gate && !(wr_en && ctrl_sel)) |=> out);

  assert_snapshot_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(latched) && latched) |-> (lval == $past(lval)));

  assert_latch_drop_R13: assert property (@(posedge clk) disable iff (!rst_n)
    cw |=> !latched);
endmodule

bind pit_channel pit_channel_checks u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .wr_en(wr_en), .ctrl_sel(ctrl_sel),
  .ctl(wr_data[5:1]), .out(out), .m(m), .latched(latched), .lval(lval)
);

// File: tb/sim_pit_channel.sv
module sim_pit_channel;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, gate = 1'b0, wr_en = 1'b0, ctrl_sel = 1'b0;
  logic rd_en = 1'b0, rd_stat = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic out;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  pit_channel u0 (.clk(clk), .rst_n(rst_n), .gate(gate), .wr_en(wr_en),
    .ctrl_sel(ctrl_sel), .wr_data(wr_data), .rd_en(rd_en), .rd_stat(rd_stat),
    .rd_data(rd_data), .out(out));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(bit c, logic [7:0] d);
    ctrl_sel = c; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    rd_stat = 1'b0; rd_en = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic stat(output logic [7:0] v);
    rd_stat = 1'b1;
    #1 v = rd_data;
    rd_stat = 1'b0;
  endtask

  function automatic logic rate_out(int md, int n, int k);
    if (md == 2) return (k % n) != (n - 1);
    return (k % n) < ((n + 1) / 2);
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] s, lo, hi;
    int code, n, eff;
    void'($urandom(32'd4242));
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    stat(s); chk("R12 reset status", s, 8'hF0);
    chk("R1 reset out", out, 1'b1);

    gate = 1'b1;
    wr(1, 8'h30);
    stat(s); chk("R12 mode0 status", s, 8'h70);
    chk("R1 mode0 idle low", out, 1'b0);
    wr(0, 8'd5); wr(0, 8'd0);
    for (int k = 1; k <= 7; k++) begin
      cyc(1); chk("R3 mode0 terminal", out, (k >= 6));
    end

    wr(1, 8'h30); wr(0, 8'd6); wr(0, 8'd0);
    for (int k = 1; k <= 12; k++) begin
      gate = !(k >= 3 && k <= 5);
      cyc(1); chk("R3 mode0 gate pause", out, (k >= 10));
    end
    gate = 1'b1;

    wr(1, 8'h20); wr(0, 8'h01);
    cyc(256); chk("R10 high byte only low", out, 1'b0);
    cyc(1);   chk("R10 high byte only rise", out, 1'b1);

    wr(1, 8'h18);
    chk("R1 mode4 idle high", out, 1'b1);
    wr(0, 8'd3);
    for (int k = 1; k <= 7; k++) begin
      cyc(1); chk("R7 R10 mode4 strobe", out, (k != 4));
    end

    gate = 1'b0;
    wr(1, 8'h1A); wr(0, 8'd4);
    cyc(3); chk("R8 mode5 waits for gate", out, 1'b1);
    for (int r = 0; r < 2; r++) begin
      gate = 1'b1;
      for (int k = 0; k <= 6; k++) begin
        cyc(1); chk("R8 mode5 strobe", out, (k != 4));
      end
      gate = 1'b0; cyc(2);
    end

    wr(1, 8'h32); wr(0, 8'd4); wr(0, 8'd0);
    cyc(2); chk("R4 mode1 armed idle", out, 1'b1);
    for (int j = 0; j <= 10; j++) begin
      gate = (j != 2);
      cyc(1); chk("R4 mode1 retrigger", out, (j >= 7));
    end

    gate = 1'b1;
    wr(1, 8'h34); wr(0, 8'd3); wr(0, 8'd0);
    cyc(2);
    gate = 1'b0;
    for (int k = 0; k < 6; k++) begin
      cyc(1); chk("R9 gate low holds high", out, 1'b1);
    end
    gate = 1'b1;
    for (int k = 0; k <= 8; k++) begin
      cyc(1); chk("R9 gate restart", out, rate_out(2, 3, k));
    end

    wr(1, 8'h34); wr(0, 8'h34); wr(0, 8'h12);
    cyc(5); wr(1, 8'h00);
    cyc(4); rd(lo); rd(hi);
    chk("R11 latched snapshot", {hi, lo}, 16'h1230);

    wr(1, 8'h34); wr(0, 8'h55);
    wr(1, 8'h34); wr(0, 8'h10); wr(0, 8'h00);
    cyc(2); wr(1, 8'h00); rd(lo); rd(hi);
    chk("R13 write order reset", {hi, lo}, 16'h000F);

    wr(1, 8'h00);
    wr(1, 8'h34); wr(0, 8'h20); wr(0, 8'h00);
    cyc(2); wr(1, 8'h00); rd(lo); rd(hi);
    chk("R13 latch discarded", {hi, lo}, 16'h001F);
    stat(s); chk("R12 status armed", s, 8'hB4);

    wr(1, 8'h3C); stat(s); chk("R2 code6 status", s, 8'hF4);
    wr(1, 8'h3E); stat(s); chk("R2 code7 status", s, 8'hF6);

    for (int it = 0; it < 10; it++) begin
      case ($urandom % 4)
        0: code = 2;
        1: code = 3;
        2: code = 6;
        default: code = 7;
      endcase
      n = 2 + int'($urandom % 30);
      eff = (code % 2 == 1) ? 3 : 2;
      wr(1, {2'b00, 2'b11, 3'(code), 1'b0});
      wr(0, 8'(n)); wr(0, 8'h00);
      for (int k = 0; k <= 2 * n + 2; k++) begin
        cyc(1);
        if (eff == 2) chk(code > 5 ? "R2 R5 alias rate" : "R5 rate", out, rate_out(2, n, k));
        else          chk(code > 5 ? "R2 R6 alias square" : "R6 square", out, rate_out(3, n, k));
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule